// File: doc/BRIEF.md
# Unequal-Block Carry-Select Adder

This block is a purely combinational 19-bit binary adder. It adds two operands and a carry input, and it returns a 19-bit sum and a carry output. The operand is cut into four slices. From the least significant end, the slices are 4, 4, 5 and 6 bits wide.

The lowest slice is a single ripple-carry adder, driven by the real carry input. Each higher slice computes its result twice at the same time, once assuming an incoming carry of 0 and once assuming 1. A 2:1 multiplexer then keeps one of the two results, steered by the carry that leaves the slice below. The slices grow toward the top because each higher select carry arrives one mux delay later, which gives a longer ripple time to finish.

All seven adders are instances of one parameterized ripple adder, built from a generated chain of full-adder cells. Count one unit for a full adder and one for a 2:1 mux. The longest path is then the 4-unit ripple of the lowest slice plus three mux stages, 7 units in total.

Top module: `csa_adder19`

## Requirements
- R1: For every input, the 20-bit value {cout, sum} equals a + b + cin as unsigned numbers.
- R2: sum[3:0] equals the low four bits of a[3:0] + b[3:0] + cin.
- R3: Each upper slice (bits 7:4, 12:8 and 18:13) outputs its own slice of a plus its own slice of b plus the carry that comes out of the slice below, keeping the slice width.
- R4: The carry that enters bit 4, bit 8 and bit 13 equals the arithmetic carry out of the lower bits: bit p of (a mod 2^p) + (b mod 2^p) + cin, for p = 4, 8 and 13.
- R5: In each upper slice, the candidate computed with an assumed carry of 1 equals the candidate computed with an assumed carry of 0, plus one, including its carry bit.
- R6: a all ones, b zero and cin = 1 give sum = 0 and cout = 1.
- R7: a and b all ones with cin = 1 give sum all ones and cout = 1.
- R8: All-zero inputs give sum = 0 and cout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 19 | First addend |
| b | input | 19 | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 19 | Sum bits |
| cout | output | 1 | Carry out of bit 18 |

## Verification
The assertions assume that every input holds a known 0 or 1. They also assume they are evaluated only after the combinational network has settled for the current operands. The bench drives every bit explicitly and holds each vector steady for half a bench clock period before it samples. It sweeps every bit pattern in a window that straddles each slice boundary, with both carry-in values, and then adds long runs of random operands. Every stimulus is therefore a fully defined, settled input.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int unsigned CSA_NBLK = 4;

  // Bit position where slice k begins, given the widths of the three lower slices.
  function automatic int unsigned blk_lo(input int unsigned w0, input int unsigned w1,
                                         input int unsigned w2, input int unsigned k);
    int unsigned lo;
    lo = 0;
    if (k >= 1) lo = lo + w0;
    if (k >= 2) lo = lo + w1;
    if (k >= 3) lo = lo + w2;
    return lo;
  endfunction

  // Width of slice k.
  function automatic int unsigned blk_w(input int unsigned w0, input int unsigned w1,
                                        input int unsigned w2, input int unsigned w3,
                                        input int unsigned k);
    case (k)
      0:       return w0;
      1:       return w1;
      2:       return w2;
      default: return w3;
    endcase
  endfunction

endpackage

// File: rtl/csa_fa.sv
module csa_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic hs;

  assign hs = x ^ y;
  assign s  = hs ^ ci;
  assign co = (x & y) | (hs & ci);
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic         cout
);
  logic [N:0] cc;

  assign cc[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_bit
    csa_fa u_fa (
      .x  (a[i]),
      .y  (b[i]),
      .ci (cc[i]),
      .s  (s[i]),
      .co (cc[i+1])
    );
  end

  assign cout = cc[N];
endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s0;
  logic [W-1:0] s1;
  logic         c0;
  logic         c1;

  csa_ripple #(.N(W)) u_guess0 (
    .a    (a),
    .b    (b),
    .cin  (1'b0),
    .s    (s0),
    .cout (c0)
  );

  csa_ripple #(.N(W)) u_guess1 (
    .a    (a),
    .b    (b),
    .cin  (1'b1),
    .s    (s1),
    .cout (c1)
  );

  always_comb begin
    if (sel) begin
      s  = s1;
      co = c1;
    end else begin
      s  = s0;
      co = c0;
    end
  end
endmodule

// File: rtl/csa_adder19.sv
module csa_adder19 #(
  parameter  int unsigned W0    = 4,
  parameter  int unsigned W1    = 4,
  parameter  int unsigned W2    = 5,
  parameter  int unsigned W3    = 6,
  localparam int unsigned WIDTH = W0 + W1 + W2 + W3
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import csa_pkg::*;

  // bc[k] is the carry entering slice k; bc[CSA_NBLK] leaves the top slice.
  logic [CSA_NBLK:0] bc;

  assign bc[0] = cin;

  csa_ripple #(.N(W0)) u_base (
    .a    (a[W0-1:0]),
    .b    (b[W0-1:0]),
    .cin  (bc[0]),
    .s    (sum[W0-1:0]),
    .cout (bc[1])
  );

  for (genvar k = 1; k < CSA_NBLK; k++) begin : g_blk
    localparam int unsigned LO = blk_lo(W0, W1, W2, k);
    localparam int unsigned BW = blk_w(W0, W1, W2, W3, k);
    localparam int unsigned HI = LO + BW - 1;

    csa_select_block #(.W(BW)) u_sel (
      .a   (a[HI:LO]),
      .b   (b[HI:LO]),
      .sel (bc[k]),
      .s   (sum[HI:LO]),
      .co  (bc[k+1])
    );
  end

  assign cout = bc[CSA_NBLK];
endmodule

// File: rtl/csa_adder19_chk.sv
module csa_adder19_chk #(
  parameter  int unsigned W0    = 4,
  parameter  int unsigned W1    = 4,
  parameter  int unsigned W2    = 5,
  parameter  int unsigned W3    = 6,
  localparam int unsigned WIDTH = W0 + W1 + W2 + W3
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [4:0]       bc
);
  import csa_pkg::*;

  always_comb begin
    logic [WIDTH:0] full;
    logic [WIDTH:0] part;
    logic [WIDTH:0] msk;
    int unsigned    lo;
    full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    // R1
    a_r1_full_sum: assert ({cout, sum} == full)
      else $error("R1 total sum mismatch");
    // R2
    a_r2_base_slice: assert (sum[W0-1:0] == full[W0-1:0])
      else $error("R2 base slice mismatch");
    // R4: select carries agree with the arithmetic carry at each boundary
    for (int unsigned k = 1; k < CSA_NBLK; k++) begin
      lo   = blk_lo(W0, W1, W2, k);
      msk  = ({(WIDTH+1){1'b1}} >> (WIDTH + 1 - lo));
      part = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{WIDTH{1'b0}}, cin};
      a_r4_boundary_carry: assert (bc[k] == part[lo])
        else $error("R4 carry into slice %0d mismatch", k);
    end
    // R6
    if (&a && b == '0 && cin) begin
      a_r6_wrap_to_zero: assert (sum == '0 && cout)
        else $error("R6 all-ones plus one mismatch");
    end
    // R7
    if (&a && &b && cin) begin
      a_r7_max_operands: assert (&sum && cout)
        else $error("R7 maximum operands mismatch");
    end
  end
endmodule

module csa_select_chk #(
  parameter int unsigned W = 5
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         sel,
  input logic [W-1:0] s0,
  input logic         c0,
  input logic [W-1:0] s1,
  input logic         c1,
  input logic [W-1:0] s,
  input logic         co
);
  always_comb begin
    // R5
    a_r5_guess_step: assert ({c1, s1} == {c0, s0} + {{W{1'b0}}, 1'b1})
      else $error("R5 candidates do not differ by one");
    // R3
    a_r3_slice_result: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{W{1'b0}}, sel})
      else $error("R3 slice result mismatch");
  end
endmodule

bind csa_adder19 csa_adder19_chk #(.W0(W0), .W1(W1), .W2(W2), .W3(W3)) u_chk (
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout),
  .bc   (bc)
);

bind csa_select_block csa_select_chk #(.W(W)) u_sel_chk (
  .a   (a),
  .b   (b),
  .sel (sel),
  .s0  (s0),
  .c0  (c0),
  .s1  (s1),
  .c1  (c1),
  .s   (s),
  .co  (co)
);

// File: tb/csa_adder19_test.sv
module csa_adder19_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 19;

  logic          clk;
  logic [WD-1:0] a;
  logic [WD-1:0] b;
  logic          cin;
  logic [WD-1:0] sum;
  logic          cout;

  int n_vec;
  int n_bad;

  csa_adder19 uut (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint unsigned carry_at(input longint unsigned va, input longint unsigned vb,
                                                input longint unsigned vc, input int p);
    longint unsigned m;
    m = (64'd1 << p) - 1;
    return (((va & m) + (vb & m) + vc) >> p) & 1;
  endfunction

  task automatic cmp(input string req, input longint unsigned got, input longint unsigned exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h expected=%h", req, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [WD-1:0] va, input logic [WD-1:0] vb, input logic vc);
    longint unsigned exp;
    int lo [4];
    int w  [4];
    a   = va;
    b   = vb;
    cin = vc;
    #(CLK_PERIOD / 2);
    lo = '{0, 4, 8, 13};
    w  = '{4, 4, 5, 6};
    exp = longint'(va) + longint'(vb) + longint'(vc);
    cmp("R1", {cout, sum}, exp);
    cmp("R2", sum[3:0], exp & 15);
    for (int k = 1; k < 4; k++) begin
      longint unsigned m;
      longint unsigned sl;
      m  = (64'd1 << w[k]) - 1;
      sl = ((longint'(va) >> lo[k]) & m) + ((longint'(vb) >> lo[k]) & m)
           + carry_at(va, vb, vc, lo[k]);
      cmp("R3", (longint'(sum) >> lo[k]) & m, sl & m);
      // R4: with both operand bits clear at the boundary, the sum bit shows the carry in
      if (va[lo[k]] == 1'b0 && vb[lo[k]] == 1'b0)
        cmp("R4", sum[lo[k]], carry_at(va, vb, vc, lo[k]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int bnd [3];
    n_vec = 0;
    n_bad = 0;
    bnd = '{4, 8, 13};

    // R8: quiet inputs
    apply('0, '0, 1'b0);
    cmp("R8", {cout, sum}, 0);

    // R6: all ones plus one wraps to zero
    apply('1, '0, 1'b1);
    cmp("R6", {cout, sum}, 20'h80000);
    apply('0, '1, 1'b1);
    cmp("R6", {cout, sum}, 20'h80000);
    apply('1, 19'd1, 1'b0);
    cmp("R6", {cout, sum}, 20'h80000);

    // R7: largest operands
    apply('1, '1, 1'b1);
    cmp("R7", {cout, sum}, 20'hFFFFF);

    // R2: exhaustive lowest slice with fixed upper bits
    for (int i = 0; i < 512; i++) begin
      apply({15'h2a5c, 4'(i)}, {15'h1337, 4'(i >> 4)}, i[8]);
    end

    // R4, R5: exhaustive 4+4 bit window across each boundary, both carry inputs;
    // toggling cin under propagate patterns switches the upper candidates
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 512; i++) begin
        logic [WD-1:0] va;
        logic [WD-1:0] vb;
        va = (19'(i & 15) << (bnd[k] - 2)) | ((19'd1 << (bnd[k] - 2)) - 1);
        vb = 19'((i >> 4) & 15) << (bnd[k] - 2);
        apply(va, vb, i[8]);
      end
      // R5: full propagate chain up to the boundary, carry arrives from cin alone
      apply((19'd1 << bnd[k]) - 1, '0, 1'b1);
      cmp("R5", sum[bnd[k]], 1);
      apply((19'd1 << bnd[k]) - 1, '0, 1'b0);
      cmp("R5", sum[bnd[k]], 0);
    end

    // R1: random operands
    for (int i = 0; i < 10000; i++) begin
      apply(19'($urandom), 19'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule